// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer ratio and marks the end of every division cycle with a single-cycle pulse. A synchronous counter stands in for a prescaler that divides by either 32 or 33. A swallow count selects how many prescaler periods use the longer modulus. A main count sets how many prescaler periods make up one complete cycle. The resulting ratio is N = 33·S + 32·(M − S), which simplifies to 32·M + S.

The swallow value S (5 bits, 0 to 31) and the main value M (11 bits) come from a control register and are level inputs. The block samples them only at a cycle boundary, so values changed in the middle of a cycle do not disturb the cycle in progress. A main value below 32 is raised to 32, which guarantees that the swallow count never exceeds the main count. The largest ratio is 32·2047 + 31 = 65535.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` stays 0. The first rising edge of `clk_in` after release loads S and M. `div_pulse` first goes high in the N-th input clock cycle after that load edge.
- R2: Consecutive rising edges of `div_pulse` are exactly N = 32·M + S input clocks apart, for any S in 0..31 and M in 32..2047.
- R3: `div_pulse` is high for exactly one input clock cycle per division cycle.
- R4: With S = 0, the period is exactly 32·M input clocks.
- R5: The extreme settings divide correctly: S = 31 with M = 2047 gives 65535, and S = 31 with M = 32 gives 1055.
- R6: A main value below 32, including 0, acts as 32. For example, S = 3 with M = 5 gives 1027, and S = 0 with M = 0 gives 1024.
- R7: `swallow_val` and `main_val` are sampled only on the clock edge that ends a cycle (the edge after `div_pulse` is high). A change at any other time leaves the current period unchanged and takes effect in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_val | input | 5 | Swallow count S: number of divide-by-33 prescaler periods per cycle |
| main_val | input | 11 | Main count M: total prescaler periods per cycle (values below 32 act as 32) |
| div_pulse | output | 1 | One-clock pulse in the last input clock of every division cycle |

## Verification
Every internal fault leads either to a wrong spacing between pulses or to a pulse longer than one clock. Either symptom becomes visible at `div_pulse` within one division cycle, which is at most 65535 input clocks. A swallow counter that fails to stop at zero, or a prescaler held in the wrong modulus, shifts the period by a few counts. The bench measures the exact spacing, so such an error is caught at the first pulse after the faulty cycle. A value sampled at the wrong moment changes the length of the cycle in which it was written rather than the following one, so the bench changes its inputs in the middle of a cycle and checks both of the resulting periods.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int S_W   = 5,
  parameter int M_W   = 11,
  parameter int P_LOG = 5
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic [S_W-1:0] swallow_val,
  input  logic [M_W-1:0] main_val,
  output logic           div_pulse
);
  localparam int P = 1 << P_LOG;
  localparam int PC_W = P_LOG + 1;
  localparam logic [M_W-1:0] M_FLOOR = M_W'(P);

  logic [PC_W-1:0] pre_cnt;
  logic [S_W-1:0]  sw_rem;
  logic [M_W-1:0]  main_rem;
  logic            armed;

  wire             swallowing = (sw_rem != '0);
  wire [PC_W-1:0]  pre_top    = swallowing ? PC_W'(P) : PC_W'(P - 1);
  wire             pre_out    = (pre_cnt == pre_top);
  wire [M_W-1:0]   m_eff      = (main_val < M_FLOOR) ? M_FLOOR : main_val;
  wire             reload     = !armed || div_pulse;

  assign div_pulse = armed && pre_out && (main_rem == M_W'(1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      pre_cnt  <= '0;
      sw_rem   <= '0;
      main_rem <= '0;
    end else if (reload) begin
      armed    <= 1'b1;
      pre_cnt  <= '0;
      sw_rem   <= swallow_val;
      main_rem <= m_eff;
    end else if (pre_out) begin
      pre_cnt  <= '0;
      main_rem <= main_rem - M_W'(1);
      if (swallowing) sw_rem <= sw_rem - S_W'(1);
    end else begin
      pre_cnt  <= pre_cnt + PC_W'(1);
    end
  end
endmodule

module pulse_swallow_div_chk #(
  parameter int S_W   = 5,
  parameter int M_W   = 11,
  parameter int P_LOG = 5
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic [S_W-1:0]   swallow_val,
  input logic             div_pulse,
  input logic [P_LOG:0]   pre_cnt,
  input logic [S_W-1:0]   sw_rem,
  input logic [M_W-1:0]   main_rem,
  input logic             armed
);
  localparam int P = 1 << P_LOG;

  // R3
  pulse_width_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R6
  reload_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    div_pulse |=> (main_rem >= M_W'(P)) && (sw_rem == $past(swallow_val)));

  // R2
  modulus_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (pre_cnt == (P_LOG+1)'(P)) |-> (sw_rem != '0));

  // R2
  swallow_bound_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    armed |-> ({{(M_W > S_W ? M_W - S_W : 1){1'b0}}, sw_rem} < {1'b0, main_rem}));

  // R7
  hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (armed && !div_pulse) |=> (main_rem <= $past(main_rem)));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.S_W(S_W), .M_W(M_W), .P_LOG(P_LOG)) i_chk (
  .clk_in(clk_in), .rst_n(rst_n), .swallow_val(swallow_val), .div_pulse(div_pulse),
  .pre_cnt(pre_cnt), .sw_rem(sw_rem), .main_rem(main_rem), .armed(armed)
);

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 70000;

  logic        clk_in = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  swallow_val = '0;
  logic [10:0] main_val = '0;
  logic        div_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  pulse_swallow_div i_pulse_swallow_div (
    .clk_in(clk_in), .rst_n(rst_n), .swallow_val(swallow_val),
    .main_val(main_val), .div_pulse(div_pulse)
  );

  always #(CLK_PERIOD/2) clk_in = ~clk_in;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Called at a falling edge where div_pulse is high; returns clocks to the next pulse.
  task automatic measure(input string req, output int n);
    n = 0;
    do begin
      @(negedge clk_in);
      n++;
      if (n == 1) check(div_pulse == 1'b0, "R3", div_pulse, 0);
    end while (!div_pulse && n < LIMIT);
  endtask

  task automatic t_reset();
    int n;
    swallow_val = 5'd5;
    main_val = 11'd32;
    rst_n = 1'b0;
    repeat (3) @(negedge clk_in);
    check(div_pulse == 1'b0, "R1", div_pulse, 0);
    @(negedge clk_in);
    check(div_pulse == 1'b0, "R1", div_pulse, 0);
    rst_n = 1'b1;
    @(posedge clk_in);
    n = 0;
    do begin
      @(negedge clk_in);
      n++;
    end while (!div_pulse && n < LIMIT);
    check(n == 1029, "R1", n, 1029);
  endtask

  task automatic t_period(input int s, input int m, input int exp, input string req);
    int n;
    swallow_val = 5'(s);
    main_val = 11'(m);
    measure(req, n);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_midcycle();
    int n;
    swallow_val = 5'd9;
    main_val = 11'd60;
    n = 0;
    do begin
      @(negedge clk_in);
      n++;
      if (n == 200) begin
        swallow_val = 5'd7;
        main_val = 11'd50;
      end
    end while (!div_pulse && n < LIMIT);
    check(n == 1929, "R7", n, 1929);
    measure("R7", n);
    check(n == 1607, "R7", n, 1607);
  endtask

  initial begin
    t_reset();
    t_period(5, 32, 1029, "R2");
    t_period(17, 100, 3217, "R2");
    t_period(0, 40, 1280, "R4");
    t_period(3, 5, 1027, "R6");
    t_period(0, 0, 1024, "R6");
    t_midcycle();
    t_period(31, 2047, 65535, "R5");
    t_period(31, 32, 1055, "R5");
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk_in);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule